// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Framer

This block sits between an instruction fetch path that delivers 16-bit parcels and a decoder that wants whole instructions. Parcels arrive one per accepted beat on a valid/ready input, lowest address first. The framer looks at the low bits of the first parcel of each instruction, works out from a prefix code how many parcels make up that instruction (one to eleven, i.e. 16 to 176 bits), gathers them, and then presents the assembled instruction on a valid/ready output. Each output beat carries the instruction data, its length in parcels, and an error flag.

Prefixes that are set aside for instructions of 192 bits or longer are not framed. The framer flags them instead: it emits the lone first parcel with the error flag set and resumes framing at the next parcel. Downstream backpressure stalls the parcel input, so no parcel is dropped or repeated. When the output is taken in the same cycle that a new parcel arrives, the framer keeps running at one parcel per cycle.

Top module: `parcel_framer`

## Requirements
- R1: A synchronous reset, held for at least one clock, clears `out_valid`, raises `in_ready`, and throws away any instruction that is only partly collected. The first parcel accepted after reset starts a new instruction.
- R2: A first parcel whose bits [1:0] are 00, 01 or 10 yields a beat of length 1 with `out_err` = 0.
- R3: A first parcel with bits [1:0] = 11 and bits [4:2] not equal to 111 yields a beat of length 2 with `out_err` = 0.
- R4: A first parcel with bits [5:0] = 011111 yields a beat of length 3 with `out_err` = 0.
- R5: A first parcel with bits [6:0] = 0111111 yields a beat of length 4 with `out_err` = 0.
- R6: A first parcel with bits [6:0] = 1111111 and bits [14:12] = n, for n from 0 to 6, yields a beat of length 5+n with `out_err` = 0.
- R7: A first parcel with bits [6:0] = 1111111 and bits [14:12] = 111 yields one beat that holds only that parcel in `out_data`[15:0], with `out_err` = 1 and `out_len` = 1. The next parcel is taken as the first parcel of a new instruction.
- R8: The first parcel of an instruction appears in `out_data`[15:0] and parcel k (counting from 0) appears in `out_data`[16k+15:16k]. All bits at or above 16 times `out_len` are zero.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data`, `out_len` and `out_err` hold steady. Every parcel accepted at the input appears exactly once, in order, in the output beats.
- R10: When a beat is taken (`out_valid` and `out_ready` both 1), `in_ready` is 1 in the same cycle. A stream of one-parcel instructions with `out_ready` held at 1 therefore never sees `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A parcel is offered |
| in_ready | output | 1 | The framer accepts the offered parcel this cycle |
| in_parcel | input | 16 | Parcel data |
| out_valid | output | 1 | An assembled instruction is presented |
| out_ready | input | 1 | The consumer takes the presented instruction |
| out_data | output | 176 | Assembled instruction, first parcel in the low bits, zero above the length |
| out_len | output | 4 | Instruction length in parcels (1 to 11) |
| out_err | output | 1 | The first parcel carried a reserved long-form prefix |

## Verification
In one cycle, two things can happen together: the consumer takes a finished instruction, and a new first parcel is accepted. That new parcel may itself be a complete one-parcel instruction, which must replace the beat just handed off without a gap. The bench provokes this in two ways. First, it streams one-parcel instructions back to back with the output always ready, and requires that `in_ready` never falls. Second, it runs a mixed-length stream against a pseudo-random `out_ready`. In both cases it compares every beat with lengths computed from the prefix rules, and it checks that a stalled beat never changes and never lets a parcel in.

// File: rtl/framer_pkg.sv
package framer_pkg;

   // Bits per parcel and the largest legal instruction, in parcels.
   parameter int unsigned PFR_PARCEL_W   = 16;
   parameter int unsigned PFR_MAX_PARCEL = 11;

   // Prefix classes recognised by the length decoder.
   typedef enum logic [2:0] {
      CLS_HALF  = 3'd0,
      CLS_WORD  = 3'd1,
      CLS_W48   = 3'd2,
      CLS_W64   = 3'd3,
      CLS_LONG  = 3'd4,
      CLS_RSVD  = 3'd5
   } pfr_cls_e;

endpackage

// File: rtl/pfr_len_decode.sv
module pfr_len_decode
   import framer_pkg::*;
#(
   parameter int unsigned PARCEL_W   = PFR_PARCEL_W,
   parameter int unsigned MAX_PARCEL = PFR_MAX_PARCEL,
   localparam int unsigned LEN_W     = $clog2(MAX_PARCEL + 1)
) (
   input  logic [PARCEL_W-1:0] parcel_i,
   output pfr_cls_e            cls_o,
   output logic [LEN_W-1:0]    len_o,
   output logic                rsvd_o
);

   logic       long_pfx;
   logic [2:0] ext_cnt;
   logic       long_ok;
   logic [3:0] raw_len;
   pfr_cls_e   raw_cls;

   assign long_pfx = (parcel_i[6:0] == 7'b1111111);
   assign ext_cnt  = parcel_i[14:12];

   // The long forms are legal only if the configured width can hold them.
   generate
      if (MAX_PARCEL >= 5) begin : g_long
         assign long_ok = (ext_cnt != 3'b111) &&
                          ((32'd5 + 32'(ext_cnt)) <= MAX_PARCEL);
      end else begin : g_nolong
         assign long_ok = 1'b0;
      end
   endgenerate

   // The most specific prefix wins.
   always_comb begin
      raw_cls = CLS_HALF;
      raw_len = 4'd1;
      if (long_pfx) begin
         raw_cls = long_ok ? CLS_LONG : CLS_RSVD;
         raw_len = long_ok ? (4'd5 + {1'b0, ext_cnt}) : 4'd1;
      end else if (parcel_i[6:0] == 7'b0111111) begin
         raw_cls = CLS_W64;
         raw_len = 4'd4;
      end else if (parcel_i[5:0] == 6'b011111) begin
         raw_cls = CLS_W48;
         raw_len = 4'd3;
      end else if (parcel_i[1:0] == 2'b11) begin
         raw_cls = (parcel_i[4:2] != 3'b111) ? CLS_WORD : CLS_RSVD;
         raw_len = (parcel_i[4:2] != 3'b111) ? 4'd2 : 4'd1;
      end
   end

   // A class longer than the configured width is treated as reserved.
   always_comb begin
      cls_o  = raw_cls;
      rsvd_o = (raw_cls == CLS_RSVD);
      len_o  = LEN_W'(raw_len);
      if (32'(raw_len) > MAX_PARCEL) begin
         cls_o  = CLS_RSVD;
         rsvd_o = 1'b1;
         len_o  = LEN_W'(1);
      end
   end

   always_comb begin
      if (rsvd_o) begin
         a_rsvd_len_r7 : assert (len_o == LEN_W'(1))
            else $error("reserved prefix must decode to a single parcel");
      end
   end

endmodule

// File: rtl/pfr_slot_bank.sv
module pfr_slot_bank
   import framer_pkg::*;
#(
   parameter int unsigned PARCEL_W   = PFR_PARCEL_W,
   parameter int unsigned MAX_PARCEL = PFR_MAX_PARCEL,
   localparam int unsigned LEN_W     = $clog2(MAX_PARCEL + 1),
   localparam int unsigned DATA_W    = PARCEL_W * MAX_PARCEL
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start_i,
   input  logic                wr_en_i,
   input  logic [LEN_W-1:0]    wr_idx_i,
   input  logic [PARCEL_W-1:0] parcel_i,
   output logic [DATA_W-1:0]   data_o
);

   // Slot 0 loads the first parcel. A start clears the other slots, so the
   // bits above the length read as zero.
   generate
      for (genvar i = 0; i < MAX_PARCEL; i++) begin : g_slot
         logic [PARCEL_W-1:0] q;
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst)          q <= '0;
               else if (start_i) q <= parcel_i;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (rst)
                  q <= '0;
               else if (start_i)
                  q <= '0;
               else if (wr_en_i && (wr_idx_i == LEN_W'(i)))
                  q <= parcel_i;
            end
         end
         assign data_o[i*PARCEL_W +: PARCEL_W] = q;
      end
   endgenerate

   p_no_head_write_r8 : assert property (@(posedge clk) disable iff (rst)
      wr_en_i |-> (wr_idx_i != '0) && (32'(wr_idx_i) < MAX_PARCEL));

endmodule

// File: rtl/pfr_ctrl.sv
module pfr_ctrl
   import framer_pkg::*;
#(
   parameter int unsigned MAX_PARCEL = PFR_MAX_PARCEL,
   localparam int unsigned LEN_W     = $clog2(MAX_PARCEL + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid_i,
   output logic             in_ready_o,
   input  logic             out_ready_i,
   input  logic [LEN_W-1:0] dec_len_i,
   input  logic             dec_rsvd_i,
   output logic             start_o,
   output logic             wr_en_o,
   output logic [LEN_W-1:0] wr_idx_o,
   output logic             done_o,
   output logic [LEN_W-1:0] need_o,
   output logic             err_o
);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] need_q;
   logic             done_q;
   logic             err_q;
   logic             take;
   logic             last;

   // A finished beat that is being taken frees the input in the same cycle.
   assign in_ready_o = !done_q || out_ready_i;
   assign take       = in_valid_i && in_ready_o;
   assign start_o    = take && (cnt_q == '0);
   assign wr_en_o    = take && (cnt_q != '0);
   assign wr_idx_o   = cnt_q;
   assign last       = (cnt_q + LEN_W'(1)) == need_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         need_q <= LEN_W'(1);
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (done_q && out_ready_i)
            done_q <= 1'b0;
         if (start_o) begin
            err_q  <= dec_rsvd_i;
            need_q <= dec_len_i;
            if (dec_len_i == LEN_W'(1)) begin
               done_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               cnt_q  <= LEN_W'(1);
            end
         end else if (wr_en_o) begin
            if (last) begin
               done_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               cnt_q  <= cnt_q + LEN_W'(1);
            end
         end
      end
   end

   assign done_o = done_q;
   assign need_o = need_q;
   assign err_o  = err_q;

   p_collect_not_done_r9 : assert property (@(posedge clk) disable iff (rst)
      (cnt_q != '0) |-> !done_q && (cnt_q < need_q));

   p_reset_idle_r1 : assert property (@(posedge clk)
      rst |=> !done_q && (cnt_q == '0));

endmodule

// File: rtl/parcel_framer.sv
module parcel_framer
   import framer_pkg::*;
#(
   parameter int unsigned PARCEL_W   = PFR_PARCEL_W,
   parameter int unsigned MAX_PARCEL = PFR_MAX_PARCEL,
   localparam int unsigned LEN_W     = $clog2(MAX_PARCEL + 1),
   localparam int unsigned DATA_W    = PARCEL_W * MAX_PARCEL
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [PARCEL_W-1:0] in_parcel,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [DATA_W-1:0]   out_data,
   output logic [LEN_W-1:0]    out_len,
   output logic                out_err
);

   // The prefix fields sit at bits [14:12], and the length counter must
   // reach eleven.
   generate
      if (PARCEL_W < 15) begin : g_bad_width
         $error("parcel_framer: PARCEL_W must be at least 15");
      end
      if (MAX_PARCEL < 1 || MAX_PARCEL > 11) begin : g_bad_depth
         $error("parcel_framer: MAX_PARCEL must lie in 1..11");
      end
   endgenerate

   pfr_cls_e         dec_cls;
   logic [LEN_W-1:0] dec_len;
   logic             dec_rsvd;
   logic             start;
   logic             wr_en;
   logic [LEN_W-1:0] wr_idx;

   pfr_len_decode #(.PARCEL_W(PARCEL_W), .MAX_PARCEL(MAX_PARCEL)) u_dec (
      .parcel_i (in_parcel),
      .cls_o    (dec_cls),
      .len_o    (dec_len),
      .rsvd_o   (dec_rsvd)
   );

   pfr_ctrl #(.MAX_PARCEL(MAX_PARCEL)) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .in_valid_i  (in_valid),
      .in_ready_o  (in_ready),
      .out_ready_i (out_ready),
      .dec_len_i   (dec_len),
      .dec_rsvd_i  (dec_rsvd),
      .start_o     (start),
      .wr_en_o     (wr_en),
      .wr_idx_o    (wr_idx),
      .done_o      (out_valid),
      .need_o      (out_len),
      .err_o       (out_err)
   );

   pfr_slot_bank #(.PARCEL_W(PARCEL_W), .MAX_PARCEL(MAX_PARCEL)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start),
      .wr_en_i  (wr_en),
      .wr_idx_i (wr_idx),
      .parcel_i (in_parcel),
      .data_o   (out_data)
   );

   p_stall_blocks_in_r9 : assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   p_stall_hold_r9 : assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=>
         out_valid && $stable(out_data) && $stable(out_len) && $stable(out_err));

   p_handoff_frees_in_r10 : assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready) |-> in_ready);

   p_err_single_r7 : assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_err) |-> (out_len == LEN_W'(1)));

   p_len_range_r6 : assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_len != '0) && (32'(out_len) <= MAX_PARCEL));

   p_rsvd_class_r7 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && start) |=> (out_err == (($past(dec_cls)) == CLS_RSVD)));

endmodule

// File: tb/parcel_framer_tb.sv
module parcel_framer_tb;

   localparam int PW   = 16;
   localparam int MAXP = 11;
   localparam int DW   = PW * MAXP;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [PW-1:0] in_parcel = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [DW-1:0] out_data;
   logic [3:0]    out_len;
   logic          out_err;

   parcel_framer u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_parcel (in_parcel),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_len   (out_len),
      .out_err   (out_err)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [PW-1:0] sent[$];
   logic [DW-1:0] got_data[$];
   logic [3:0]    got_len[$];
   logic          got_err[$];

   bit            rdy_rand = 0;
   logic [15:0]   lfsr = 16'hACE1;
   int            stall_bad = 0;
   int            in_blocked = 0;
   bit            prev_stall = 0;
   logic [DW-1:0] prev_data;
   logic [3:0]    prev_len;
   logic          prev_err;

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      finish_run();
   end

   // Consumer readiness changes only on falling edges.
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rdy_rand ? lfsr[0] : 1'b1;
   end

   // Monitor samples 2 ns after the falling edge, once inputs have settled.
   always @(negedge clk) begin
      #2;
      if (rst) begin
         prev_stall = 0;
      end else begin
         if (prev_stall && (!out_valid || out_data != prev_data ||
                            out_len != prev_len || out_err != prev_err))
            stall_bad++;
         if (out_valid && !out_ready && in_ready)
            stall_bad++;
         if (in_valid && !in_ready)
            in_blocked++;
         if (out_valid && out_ready) begin
            got_data.push_back(out_data);
            got_len.push_back(out_len);
            got_err.push_back(out_err);
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         prev_len   = out_len;
         prev_err   = out_err;
      end
   end

   // Length in parcels from the prefix rules; 0 marks a reserved prefix.
   function automatic int exp_len(logic [PW-1:0] p);
      if (p[6:0] == 7'b1111111)
         return (p[14:12] == 3'b111) ? 0 : 5 + int'(p[14:12]);
      if (p[6:0] == 7'b0111111) return 4;
      if (p[5:0] == 6'b011111)  return 3;
      if (p[1:0] == 2'b11)      return 2;
      return 1;
   endfunction

   task automatic check(string tag, bit ok, string what,
                        logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the falling edge after transfer.
   task automatic push(logic [PW-1:0] p);
      in_valid  = 1'b1;
      in_parcel = p;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      sent.push_back(p);
      in_valid = 1'b0;
   endtask

   task automatic push_burst(logic [PW-1:0] ps[$]);
      foreach (ps[i]) begin
         in_valid  = 1'b1;
         in_parcel = ps[i];
         #1;
         while (!in_ready) begin
            @(negedge clk);
            #1;
         end
         @(negedge clk);
         sent.push_back(ps[i]);
      end
      in_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (40) @(negedge clk);
   endtask

   task automatic clear_logs();
      sent.delete();
      got_data.delete();
      got_len.delete();
      got_err.delete();
      stall_bad  = 0;
      in_blocked = 0;
   endtask

   // Compare every collected beat against the stream of sent parcels.
   task automatic check_stream(string tag);
      int i = 0;
      int k = 0;
      while (i < sent.size()) begin
         int            n = exp_len(sent[i]);
         logic [DW-1:0] d = '0;
         logic          e = (n == 0);
         int            use_n = e ? 1 : n;
         for (int j = 0; j < use_n; j++)
            if (i + j < sent.size()) d[j*PW +: PW] = sent[i+j];
         if (k < got_data.size()) begin
            check(tag, got_data[k] == d, "data", got_data[k], d);
            check(tag, got_len[k] == 4'(use_n), "length", DW'(got_len[k]), DW'(use_n));
            check(tag, got_err[k] == e, "error flag", DW'(got_err[k]), DW'(e));
         end
         i += use_n;
         k++;
      end
      check(tag, got_data.size() == k, "beat count", DW'(got_data.size()), DW'(k));
   endtask

   task automatic t_reset();
      logic [PW-1:0] burst[$];
      clear_logs();
      @(negedge clk);
      #1;
      check("R1", !out_valid, "out_valid after reset", DW'(out_valid), DW'(0));
      check("R1", in_ready, "in_ready after reset", DW'(in_ready), DW'(1));
      // Two parcels of a four-parcel instruction, then reset.
      @(negedge clk);
      burst = '{16'h123F, 16'h5555};
      push_burst(burst);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      clear_logs();
      #1;
      check("R1", !out_valid && in_ready, "idle after mid-frame reset",
            DW'({out_valid, in_ready}), DW'(2'b01));
      @(negedge clk);
      push(16'h0A01);
      drain();
      check_stream("R1");
   endtask

   task automatic t_kind(string tag, logic [PW-1:0] first, int n, logic [PW-1:0] seed);
      logic [PW-1:0] burst[$];
      clear_logs();
      burst.push_back(first);
      for (int j = 1; j < n; j++) burst.push_back(seed + PW'(j * 16'h1111));
      push_burst(burst);
      drain();
      check_stream(tag);
   endtask

   task automatic t_short();
      t_kind("R2", 16'h0000, 1, 16'h0);
      t_kind("R2", 16'hF235, 1, 16'h0);
      t_kind("R2", 16'hABFE, 1, 16'h0);
   endtask

   task automatic t_word();
      t_kind("R3", 16'h1233, 2, 16'hBEEF);
      t_kind("R3", 16'hFFEF, 2, 16'h0C0D);
   endtask

   task automatic t_48();
      t_kind("R4", 16'h801F, 3, 16'h2468);
   endtask

   task automatic t_64();
      t_kind("R5", 16'h543F, 4, 16'h1357);
   endtask

   task automatic t_long();
      for (int n = 0; n < 7; n++)
         t_kind("R6", 16'h007F | PW'(n << 12), 5 + n, PW'(16'h0F00 + n));
   endtask

   task automatic t_rsvd();
      logic [PW-1:0] burst[$];
      clear_logs();
      burst = '{16'h707F, 16'h0001, 16'hF07F, 16'h1233, 16'h9999};
      push_burst(burst);
      drain();
      check_stream("R7");
      check("R7", got_data.size() == 4, "beats after reserved prefixes",
            DW'(got_data.size()), DW'(4));
      if (got_data.size() > 0)
         check("R7", got_data[0] == DW'(16'h707F) && got_err[0],
               "reserved beat holds lone parcel", got_data[0], DW'(16'h707F));
   endtask

   task automatic t_pack();
      logic [PW-1:0] burst[$];
      logic [DW-1:0] exp_hi;
      clear_logs();
      burst.push_back(16'h607F);
      for (int j = 1; j < 11; j++) burst.push_back(16'hFFFF);
      burst.push_back(16'h3CC3);
      burst.push_back(16'h8001);
      push_burst(burst);
      drain();
      check_stream("R8");
      exp_hi = {{(DW-32){1'b0}}, 16'h8001, 16'h3CC3};
      if (got_data.size() > 1)
         check("R8", got_data[1] == exp_hi, "upper bits zero after full frame",
               got_data[1], exp_hi);
   endtask

   task automatic t_backpressure();
      logic [PW-1:0] burst[$];
      logic [PW-1:0] heads[8];
      heads = '{16'h0004, 16'h4563, 16'h201F, 16'h773F,
                16'h107F, 16'h607F, 16'h700A, 16'h707F};
      clear_logs();
      rdy_rand = 1;
      for (int j = 0; j < 32; j++) begin
         int n = exp_len(heads[j % 8]);
         burst.push_back(heads[j % 8] ^ PW'(j << 8 & 16'h0F00 & ~16'h7000));
         for (int m = 1; m < n; m++) burst.push_back(PW'(j * 97 + m * 13));
      end
      push_burst(burst);
      drain();
      rdy_rand = 0;
      @(negedge clk);
      check_stream("R9");
      check("R9", stall_bad == 0, "stalled beat changed or input open",
            DW'(stall_bad), DW'(0));
   endtask

   task automatic t_b2b();
      logic [PW-1:0] burst[$];
      clear_logs();
      for (int j = 0; j < 12; j++) burst.push_back(PW'(j * 16'h0404));
      push_burst(burst);
      drain();
      check_stream("R10");
      check("R10", in_blocked == 0, "in_ready fell during one-parcel stream",
            DW'(in_blocked), DW'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_short();
      t_word();
      t_48();
      t_64();
      t_long();
      t_rsvd();
      t_pack();
      t_backpressure();
      t_b2b();
      finish_run();
   end

endmodule